// File: doc/BRIEF.md
# Serial result readout port

This block hands a finished conversion result to a host processor over a three-wire serial link. The host pulls an active-low read select low, and the block freezes the most recent completed result into an 18-bit output shift register. The first bit goes out at once, with no clock edge needed. Each following bit moves out on a falling edge of the host's serial clock. While the select is high, the data output is released: the block raises a drive enable that an external pad buffer uses, and the pad floats whenever that enable is low.

The frame carries two status bits ahead of the magnitude: the overrange flag first, then the sign flag (1 = positive input), then 16 data bits, most significant first. The read select and the serial clock come from the host with no timing relation to the system clock. Each passes through its own flip-flop synchroniser and edge detector. Results arrive from the conversion sequencer as a one-cycle strobe with the fields beside it. The block keeps the latest result until a read takes it.

Top module: `serial_result_port`

## Requirements
- R1: After reset, `sdo_oe` is 0 and `sdo_data` is 0.
- R2: A falling edge on `rd_n` captures the latest result. `sdo_oe` rises on the third rising clock edge after the pin falls (two synchroniser stages plus the capture register), and stays high while `rd_n` is low.
- R3: When `sdo_oe` rises, `sdo_data` already shows the overrange bit of the captured result, before any serial clock edge.
- R4: The frame is bit 17 (overrange), then bit 16 (sign), then data bits 15 down to 0, where frame = {ovr, pol, data}. Each falling edge of `sclk` during a read moves to the next bit, and `sdo_data` changes on the third rising clock edge after the `sclk` pin falls.
- R5: Rising edges of `sclk` never change `sdo_data`. `sclk` activity while `rd_n` is high leaves `sdo_oe` at 0, and the next read still starts at the overrange bit.
- R6: A rising edge on `rd_n` ends the read at any point. `sdo_oe` falls on the third rising clock edge after the pin rises. The next read restarts at the overrange bit.
- R7: A new result that arrives during a read does not alter the frame being sent. The next read delivers the new result.
- R8: Once the 18th bit is showing, further `sclk` falling edges keep the last data bit on `sdo_data` until the read ends.
- R9: If a result strobe lands in the same cycle as the captured read falling edge, the new result is the one captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | One-cycle strobe: a new result is on the result fields |
| res_ovr | input | 1 | Overrange flag of the new result |
| res_pol | input | 1 | Sign flag of the new result, 1 = positive |
| res_data | input | DATA_W | Magnitude of the new result |
| rd_n | input | 1 | Host read select, active low, asynchronous |
| sclk | input | 1 | Host serial clock, asynchronous |
| sdo_data | output | 1 | Serial data toward the pad |
| sdo_oe | output | 1 | Pad drive enable; the pad floats when low |

## Verification
Two events can fall in the same clock cycle: a result strobe from the sequencer, and the capture of a synchronised read falling edge. The bench first stores a result whose flags are the opposite of the new one. It then lowers `rd_n` and pulses `res_valid` exactly in the cycle where the capture register loads, which is the third rising edge after the pin falls. The capture counts as correct when the first two bits shifted out are the new result's overrange and sign flags, not the stored ones.

// File: rtl/srp_pkg.sv
package srp_pkg;

    // Status bits sent ahead of the magnitude: overrange, then sign.
    localparam int unsigned SRP_STATUS_W = 2;

    // Minimum depth of a metastability synchroniser.
    localparam int unsigned SRP_SYNC_MIN = 2;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int unsigned        WIDTH   = 2,
    parameter int unsigned        STAGES  = srp_pkg::SRP_SYNC_MIN,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef logic [STAGES-1:0][WIDTH-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RST_VAL;
            end
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/srp_edge.sv
module srp_edge #(
    parameter int unsigned      WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] fall,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign fall[b] = prev_q[b] & ~level[b];
        assign rise[b] = ~prev_q[b] & level[b];
    end

endmodule

// File: rtl/srp_shifter.sv
module srp_shifter #(
    parameter int unsigned FRAME_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_fall,
    input  logic               rd_rise,
    input  logic               sclk_fall,
    input  logic [FRAME_W-1:0] load_frame,
    output logic               active,
    output logic               bit_out
);

    localparam int unsigned    CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               active;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_rise) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (rd_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.shreg  = load_frame;
        end else if (st_q.active && sclk_fall && (st_q.cnt != LAST)) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], 1'b0};
            st_d.cnt   = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active  = st_q.active;
    assign bit_out = st_q.shreg[FRAME_W-1];

    AST_CAPTURE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fall |=> (st_q.active && (st_q.cnt == '0)));                         // R2

    AST_RISE_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rise |=> !st_q.active);                                               // R6

    AST_ONE_STEP_PER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && sclk_fall && !rd_rise && !rd_fall && (st_q.cnt != LAST))
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));                               // R4

    AST_COUNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);                                                       // R4

    AST_LAST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && (st_q.cnt == LAST) && !rd_rise && !rd_fall)
        |=> $stable(st_q.shreg));                                                // R8

    AST_FRAME_NOT_RELOADED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !rd_fall && !rd_rise && !sclk_fall)
        |=> $stable(st_q.shreg));                                                // R7

endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = srp_pkg::SRP_SYNC_MIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic              res_ovr,
    input  logic              res_pol,
    input  logic [DATA_W-1:0] res_data,
    input  logic              rd_n,
    input  logic              sclk,
    output logic              sdo_data,
    output logic              sdo_oe
);

    localparam int unsigned FRAME_W = DATA_W + srp_pkg::SRP_STATUS_W;
    localparam int unsigned PIN_RD  = 0;
    localparam int unsigned PIN_CK  = 1;
    localparam int unsigned PINS    = 2;
    // Idle level of both host pins is high.
    localparam logic [PINS-1:0] PIN_IDLE = '1;

    typedef struct packed {
        logic [FRAME_W-1:0] hold;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [PINS-1:0]    pins_sync;
    logic [PINS-1:0]    pins_fall;
    logic [PINS-1:0]    pins_rise;
    logic [FRAME_W-1:0] new_frame;
    logic [FRAME_W-1:0] load_frame;
    logic               sh_active;
    logic               sh_bit;

    srp_sync #(
        .WIDTH   (PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sclk, rd_n}),
        .dout  (pins_sync)
    );

    srp_edge #(
        .WIDTH   (PINS),
        .RST_VAL (PIN_IDLE)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pins_sync),
        .fall  (pins_fall),
        .rise  (pins_rise)
    );

    assign new_frame = {res_ovr, res_pol, res_data};

    always_comb begin
        st_d = st_q;
        if (res_valid) begin
            st_d.hold = new_frame;
        end
        // A result landing in the capture cycle wins over the stored one.
        load_frame = res_valid ? new_frame : st_q.hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    srp_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_fall    (pins_fall[PIN_RD]),
        .rd_rise    (pins_rise[PIN_RD]),
        .sclk_fall  (pins_fall[PIN_CK]),
        .load_frame (load_frame),
        .active     (sh_active),
        .bit_out    (sh_bit)
    );

    assign sdo_oe   = sh_active;
    assign sdo_data = sh_active & sh_bit;

    AST_CAPTURE_TAKES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_fall[PIN_RD] && res_valid) |=> (sdo_oe && (sdo_data == $past(res_ovr))));  // R9

    AST_FIRST_BIT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_fall[PIN_RD] && !res_valid) |=> (sdo_oe && (sdo_data == $past(st_q.hold[FRAME_W-1])))); // R3

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sdo_oe && !pins_fall[PIN_RD]) |=> !sdo_oe);                           // R5

endmodule

// File: tb/serial_result_port_test.sv
module serial_result_port_test;

    localparam int DW = 16;
    localparam int FW = DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_valid = 1'b0;
    logic          res_ovr = 1'b0;
    logic          res_pol = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic          rd_n = 1'b1;
    logic          sclk = 1'b1;
    logic          sdo_data;
    logic          sdo_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_result_port #(.DATA_W(DW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_valid (res_valid),
        .res_ovr   (res_ovr),
        .res_pol   (res_pol),
        .res_data  (res_data),
        .rd_n      (rd_n),
        .sclk      (sclk),
        .sdo_data  (sdo_data),
        .sdo_oe    (sdo_oe)
    );

    localparam logic [FW-1:0] FR_A = {1'b1, 1'b0, 16'hA5C3};
    localparam logic [FW-1:0] FR_B = {1'b0, 1'b1, 16'h3C5A};
    localparam logic [FW-1:0] FR_C = {1'b1, 1'b0, 16'h0F0F};

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_result(input logic [FW-1:0] fr);
        res_valid = 1'b1;
        {res_ovr, res_pol, res_data} = fr;
        tick(1);
        res_valid = 1'b0;
    endtask

    // Lower READ; the port opens on the third rising edge.
    task automatic open_read(input logic [FW-1:0] fr, input string req);
        rd_n = 1'b0;
        tick(2);
        chk({req, " oe not yet"}, 32'(sdo_oe), 32'd0);
        tick(1);
        chk({req, " oe on"}, 32'(sdo_oe), 32'd1);
        chk({req, " first bit"}, 32'(sdo_data), 32'(fr[FW-1]));
    endtask

    task automatic shift_check(input logic [FW-1:0] fr, input int idx, input string req);
        sclk = 1'b0;
        tick(2);
        chk({req, " before shift"}, 32'(sdo_data), 32'(fr[FW-idx]));
        tick(1);
        chk(req, 32'(sdo_data), 32'(fr[FW-1-idx]));
        tick(2);
        sclk = 1'b1;
        tick(4);
        chk("R5 rising sclk no effect", 32'(sdo_data), 32'(fr[FW-1-idx]));
    endtask

    task automatic close_read(input string req);
        rd_n = 1'b1;
        tick(2);
        chk({req, " oe still on"}, 32'(sdo_oe), 32'd1);
        tick(1);
        chk({req, " oe off"}, 32'(sdo_oe), 32'd0);
        tick(2);
    endtask

    task automatic t_reset();
        chk("R1 oe after reset", 32'(sdo_oe), 32'd0);
        chk("R1 data after reset", 32'(sdo_data), 32'd0);
    endtask

    task automatic t_full_frame();
        put_result(FR_A);
        tick(2);
        open_read(FR_A, "R2 R3");
        for (int i = 1; i < FW; i++) begin
            shift_check(FR_A, i, "R4 frame bit");
        end
        for (int k = 0; k < 3; k++) begin
            sclk = 1'b0;
            tick(4);
            chk("R8 last bit held", 32'(sdo_data), 32'(FR_A[0]));
            sclk = 1'b1;
            tick(4);
        end
        close_read("R6");
    endtask

    task automatic t_idle_clock();
        put_result(FR_B);
        for (int k = 0; k < 6; k++) begin
            sclk = 1'b0;
            tick(4);
            chk("R5 idle oe", 32'(sdo_oe), 32'd0);
            sclk = 1'b1;
            tick(4);
        end
        open_read(FR_B, "R5 start");
        shift_check(FR_B, 1, "R5 second bit");
        close_read("R5");
    endtask

    task automatic t_abort();
        open_read(FR_B, "R6 first");
        for (int i = 1; i < 6; i++) begin
            shift_check(FR_B, i, "R6 partial");
        end
        close_read("R6 abort");
        open_read(FR_B, "R6 restart");
        shift_check(FR_B, 1, "R6 restart bit");
        close_read("R6");
    endtask

    task automatic t_update_during_read();
        open_read(FR_B, "R7 open");
        for (int i = 1; i < 4; i++) begin
            shift_check(FR_B, i, "R7 before update");
        end
        put_result(FR_A);
        tick(3);
        chk("R7 unchanged after update", 32'(sdo_data), 32'(FR_B[FW-4]));
        for (int i = 4; i < FW; i++) begin
            shift_check(FR_B, i, "R7 old frame");
        end
        close_read("R7");
        open_read(FR_A, "R7 next read");
        shift_check(FR_A, 1, "R7 next read bit");
        close_read("R7");
    endtask

    task automatic t_same_cycle();
        put_result(FR_B);
        tick(2);
        rd_n = 1'b0;
        tick(2);
        res_valid = 1'b1;
        {res_ovr, res_pol, res_data} = FR_C;
        tick(1);
        res_valid = 1'b0;
        chk("R9 oe on", 32'(sdo_oe), 32'd1);
        chk("R9 first bit new", 32'(sdo_data), 32'(FR_C[FW-1]));
        shift_check(FR_C, 1, "R9 second bit new");
        shift_check(FR_C, 2, "R9 third bit new");
        close_read("R9");
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_full_frame();
        t_idle_clock();
        t_abort();
        t_update_during_read();
        t_same_cycle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule